// File: doc/BRIEF.md
# Vector Memory Command Sequencer

This block turns one decoded vector memory command at a time into a series of wide data-bus beats. It handles loads, full-width stores and quarter-width stores. For every beat it produces the address, the address of the following line, the number of bytes to move, the write flag and a flag that marks the final beat of the command. Loads report one register write-back per vector register. Stores fetch their source registers through a read-request port. While a store is in progress, a 64-bit mask shows every register that still has a read waiting.

The command fields select the following behaviour:
- A length mode caps the total byte count from a scalar operand.
- A stride mode moves the address by the scalar operand times the element size.
- A group mode walks four consecutive, aligned registers.
- A quarter-store sends four quarter-width beats per source register.

A command is accepted only when the sequencer is idle.

Top module: `vls_seq`

## Requirements
- R1: `cmdReady` is high exactly when no command is in progress. A command is taken on a clock edge where `cmdValid` and `cmdReady` are both high. `cmdValid` has no effect while busy. `cmdReady` rises in the cycle after the final beat's handshake.
- R2: Opcode encoding: `cmdOp` 00 is a load, 01 is a store, and 1x is a quarter-store.
  - The group factor G is 4 when `cmdMulti` is 1, and 1 otherwise.
  - A command issues G beats, or 4×G beats for a quarter-store.
  - `busLast` is high only on the final beat.
- R3: The first beat's address is `cmdAddr`. If `cmdFunc[1]` is 1 (strided), each beat's address advances by `cmdScalar` × size, where `cmdSize` is 1, 2 or 4 bytes. Otherwise it advances by VBYTES, or by VBYTES/4 for a quarter-store. Addresses wrap modulo 2^32.
- R4: Byte budget:
  - If `cmdFunc[0]` is 1 (length mode), the budget is size × min(VBYTES×G/size, `cmdScalar`). Otherwise it is VBYTES×G.
  - Each beat carries min(remaining, VBYTES), or min(remaining, VBYTES/4) for a quarter-store.
  - The remaining budget is then reduced by that count.
- R5: `busAltAddr` equals `busAddr` + VBYTES. `busWrite` is high for stores and quarter-stores, and low for loads.
- R6: Register index and reads:
  - The register index is `cmdReg`. In group mode its low two bits are cleared, and it increments after each register.
  - A store makes one read request per beat, so a quarter-store reads the same register four times.
- R7: `rdTag` equals bit (`rdReg` mod 4) of `cmdTag`.
- R8: A read is consumed only on a cycle where `rdValid` and `rdReady` are high and `rdStall` is low.
  - A store beat n (counting from 0) is offered only after more than n reads have been consumed.
  - `rdValid` stays high until all reads of the command are consumed.
- R9: For a load, `wbValid` pulses in the cycle after each beat's handshake. `wbReg` then holds that beat's register.
- R10: `active` has bit r set exactly when a read for register r is still unconsumed. It is all zero when no read is pending.
- R11: The beat position advances only on a cycle where `busValid` and `busReady` are both high. While `busReady` is low, the offered beat holds its address, byte count and last flag.
- R12: After reset, `cmdReady` is 1, and `busValid`, `rdValid`, `wbValid` and `active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Sequencer idle, command can be taken |
| cmdOp | input | 2 | 00 load, 01 store, 1x quarter-store |
| cmdFunc | input | 2 | Bit 1 strided, bit 0 length-limited |
| cmdSize | input | 3 | Element size in bytes: 1, 2 or 4 |
| cmdMulti | input | 1 | Four-register group mode |
| cmdReg | input | REG_AW | First vector register index |
| cmdTag | input | 4 | Per-register tag bits |
| cmdAddr | input | ADDR_W | Start byte address |
| cmdScalar | input | 32 | Scalar operand: stride or element count |
| busValid | output | 1 | Beat offered on the data bus |
| busReady | input | 1 | Data bus accepts the beat |
| busAddr | output | ADDR_W | Beat byte address |
| busAltAddr | output | ADDR_W | Beat address plus vector byte width |
| busBytes | output | $clog2(4·VBYTES)+1 | Bytes in this beat |
| busWrite | output | 1 | Beat is a write |
| busLast | output | 1 | Final beat of the command |
| rdValid | output | 1 | Register read requested |
| rdReady | input | 1 | Register file can serve the read |
| rdStall | input | 1 | Register file holds off the read |
| rdReg | output | REG_AW | Register to read |
| rdTag | output | 1 | Tag bit for this read |
| wbValid | output | 1 | Load write-back strobe |
| wbReg | output | REG_AW | Register written back |
| active | output | 2^REG_AW | Registers with an unconsumed read |

## Verification
During a store, a register read and a bus beat can complete on the same clock edge. This happens when read n is consumed while beat n−1 is accepted. The bench produces this overlap by driving `busReady`, `rdReady` and `rdStall` from a shift-register sequence on every cycle. It keeps its own count of consumed reads and accepted beats. In every cycle it predicts `rdValid`, `busValid` and the `active` mask from those counts, so a design that advances one counter when only the other handshake fires produces a mismatch.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int GROUP  = 4;  // registers walked in group mode
  localparam int QBEATS = 4;  // beats per register for a quarter-store

  typedef struct packed {
    logic       busy;
    logic       isStore;
    logic       isQuarter;
    logic       multi;
    logic       capture;   // command accepted this cycle
    logic       beatFire;  // bus handshake this cycle
    logic       wbFire;    // load beat handshake this cycle
    logic [4:0] rdIdx;     // reads consumed so far
    logic [3:0] beatIdx;   // beats accepted so far
  } seqCtrl_t;
endpackage

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic [1:0] cmdOp,
  input  logic     cmdMulti,
  output logic     cmdReady,
  output logic     busValid,
  input  logic     busReady,
  output logic     busLast,
  output logic     busWrite,
  output logic     rdValid,
  input  logic     rdReady,
  input  logic     rdStall,
  output logic     wbValid,
  output seqCtrl_t ctl
);
  logic       busy, isStore, isQuarter, multi;
  logic [3:0] beatIdx;
  logic [4:0] rdIdx;
  logic [4:0] total;
  logic       accept, rdFire, busFire;

  always_comb begin
    total = 5'd1;
    if (multi)     total = total << 2;
    if (isQuarter) total = total << 2;
  end

  assign cmdReady = !busy;
  assign accept   = cmdValid && !busy;
  assign rdValid  = busy && isStore && (rdIdx < total);
  assign rdFire   = rdValid && rdReady && !rdStall;
  // a store beat waits until its own read has been consumed
  assign busValid = busy && (!isStore || (rdIdx > {1'b0, beatIdx}));
  assign busFire  = busValid && busReady;
  assign busLast  = busValid && ({1'b0, beatIdx} == total - 5'd1);
  assign busWrite = busy && isStore;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      isStore   <= 1'b0;
      isQuarter <= 1'b0;
      multi     <= 1'b0;
      beatIdx   <= '0;
      rdIdx     <= '0;
      wbValid   <= 1'b0;
    end else begin
      wbValid <= busFire && !isStore;
      if (accept) begin
        busy      <= 1'b1;
        isStore   <= |cmdOp;
        isQuarter <= cmdOp[1];
        multi     <= cmdMulti;
        beatIdx   <= '0;
        rdIdx     <= '0;
      end else begin
        if (rdFire) rdIdx <= rdIdx + 5'd1;
        if (busFire) begin
          beatIdx <= beatIdx + 4'd1;
          if (busLast) busy <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.busy      = busy;
    ctl.isStore   = isStore;
    ctl.isQuarter = isQuarter;
    ctl.multi     = multi;
    ctl.capture   = accept;
    ctl.beatFire  = busFire;
    ctl.wbFire    = busFire && !isStore;
    ctl.rdIdx     = rdIdx;
    ctl.beatIdx   = beatIdx;
  end
endmodule

// File: rtl/vls_dpath.sv
module vls_dpath
  import vls_pkg::*;
#(
  parameter int VBYTES = 16,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctl,
  input  logic              cmdQuarter,
  input  logic [1:0]        cmdFunc,
  input  logic [2:0]        cmdSize,
  input  logic              cmdMulti,
  input  logic [REG_AW-1:0] cmdReg,
  input  logic [3:0]        cmdTag,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [31:0]       cmdScalar,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] busAltAddr,
  output logic [$clog2(VBYTES*GROUP):0] busBytes,
  output logic [REG_AW-1:0] rdReg,
  output logic              rdTag,
  output logic [REG_AW-1:0] wbReg,
  output logic [(1<<REG_AW)-1:0] active
);
  localparam int BW = $clog2(VBYTES*GROUP) + 1;
  localparam int QB = VBYTES / QBEATS;

  logic [ADDR_W-1:0] addr, step, nextStep;
  logic [BW-1:0]     remain, budget, grpBytes, lenBudget, cap;
  logic [REG_AW-1:0] regBase, nextBase;
  logic [3:0]        tag;
  logic [1:0]        sizeLog;
  logic [31:0]       elemCap;
  logic [4:0]        rdOff;

  always_comb begin
    case (cmdSize)
      3'd2:    sizeLog = 2'd1;
      3'd4:    sizeLog = 2'd2;
      default: sizeLog = 2'd0;
    endcase
    grpBytes  = cmdMulti ? BW'(VBYTES*GROUP) : BW'(VBYTES);
    elemCap   = 32'(grpBytes) >> sizeLog;
    lenBudget = (cmdScalar < elemCap) ? BW'(cmdScalar << sizeLog) : grpBytes;
    budget    = cmdFunc[0] ? lenBudget : grpBytes;
    if (cmdFunc[1])      nextStep = ADDR_W'(cmdScalar << sizeLog);
    else if (cmdQuarter) nextStep = ADDR_W'(QB);
    else                 nextStep = ADDR_W'(VBYTES);
    nextBase  = cmdMulti ? {cmdReg[REG_AW-1:2], 2'b00} : cmdReg;
  end

  assign cap        = ctl.isQuarter ? BW'(QB) : BW'(VBYTES);
  assign busBytes   = (remain < cap) ? remain : cap;
  assign busAddr    = addr;
  assign busAltAddr = addr + ADDR_W'(VBYTES);
  assign rdOff      = ctl.isQuarter ? (ctl.rdIdx >> 2) : ctl.rdIdx;
  assign rdReg      = regBase + REG_AW'(rdOff);
  assign rdTag      = tag[rdReg[1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr    <= '0;
      step    <= '0;
      remain  <= '0;
      regBase <= '0;
      tag     <= '0;
      wbReg   <= '0;
    end else begin
      if (ctl.capture) begin
        addr    <= cmdAddr;
        step    <= nextStep;
        remain  <= budget;
        regBase <= nextBase;
        tag     <= cmdTag;
      end else if (ctl.beatFire) begin
        addr   <= addr + step;
        remain <= remain - busBytes;
      end
      if (ctl.wbFire) wbReg <= regBase + REG_AW'(ctl.beatIdx);
    end
  end

  // pending-read mask rebuilt from the read counter, one slot per group member
  always_comb begin
    active = '0;
    for (int j = 0; j < GROUP; j++) begin
      if (ctl.busy && ctl.isStore && (j == 0 || ctl.multi) &&
          int'(ctl.rdIdx) < (j + 1) * (ctl.isQuarter ? QBEATS : 1))
        active[regBase + REG_AW'(j)] = 1'b1;
    end
  end
endmodule

// File: rtl/vls_seq.sv
module vls_seq
  import vls_pkg::*;
#(
  parameter int VBYTES = 16,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [1:0]        cmdFunc,
  input  logic [2:0]        cmdSize,
  input  logic              cmdMulti,
  input  logic [REG_AW-1:0] cmdReg,
  input  logic [3:0]        cmdTag,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [31:0]       cmdScalar,
  output logic              busValid,
  input  logic              busReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] busAltAddr,
  output logic [$clog2(VBYTES*GROUP):0] busBytes,
  output logic              busWrite,
  output logic              busLast,
  output logic              rdValid,
  input  logic              rdReady,
  input  logic              rdStall,
  output logic [REG_AW-1:0] rdReg,
  output logic              rdTag,
  output logic              wbValid,
  output logic [REG_AW-1:0] wbReg,
  output logic [(1<<REG_AW)-1:0] active
);
  seqCtrl_t ctl;

  vls_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdMulti(cmdMulti), .cmdReady(cmdReady),
    .busValid(busValid), .busReady(busReady), .busLast(busLast), .busWrite(busWrite),
    .rdValid(rdValid), .rdReady(rdReady), .rdStall(rdStall),
    .wbValid(wbValid), .ctl(ctl)
  );

  vls_dpath #(.VBYTES(VBYTES), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cmdQuarter(cmdOp[1]), .cmdFunc(cmdFunc), .cmdSize(cmdSize), .cmdMulti(cmdMulti),
    .cmdReg(cmdReg), .cmdTag(cmdTag), .cmdAddr(cmdAddr), .cmdScalar(cmdScalar),
    .busAddr(busAddr), .busAltAddr(busAltAddr), .busBytes(busBytes),
    .rdReg(rdReg), .rdTag(rdTag), .wbReg(wbReg), .active(active)
  );
endmodule

// File: rtl/vls_seq_chk.sv
module vls_seq_chk #(
  parameter int VBYTES = 16,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              busValid,
  input logic              busReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic [$clog2(VBYTES*4):0] busBytes,
  input logic              busWrite,
  input logic              busLast,
  input logic              rdValid,
  input logic              rdReady,
  input logic              rdStall,
  input logic [REG_AW-1:0] rdReg,
  input logic              rdTag,
  input logic              wbValid,
  input logic [(1<<REG_AW)-1:0] active
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !busValid && !rdValid);

  p_ready_after_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busReady && busLast |=> cmdReady);

  p_beat_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid && $stable(busAddr) && $stable(busBytes) && $stable(busLast));

  p_read_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && (!rdReady || rdStall) |=> rdValid && $stable(rdReg) && $stable(rdTag));

  p_read_marked_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> active[rdReg]);

  p_mask_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> active == '0);

  p_wb_follows_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(busValid && busReady && !busWrite));
endmodule

bind vls_seq vls_seq_chk #(.VBYTES(VBYTES), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (.*);

// File: tb/test_vls_seq.sv
module test_vls_seq;
  localparam int VB  = 16;
  localparam int RAW = 6;
  localparam int BW  = $clog2(VB*4) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic           cmdValid = 0, cmdReady, cmdMulti = 0;
  logic [1:0]     cmdOp = 0, cmdFunc = 0;
  logic [2:0]     cmdSize = 1;
  logic [RAW-1:0] cmdReg = 0;
  logic [3:0]     cmdTag = 0;
  logic [31:0]    cmdAddr = 0, cmdScalar = 0;
  logic           busValid, busReady = 0, busWrite, busLast;
  logic [31:0]    busAddr, busAltAddr;
  logic [BW-1:0]  busBytes;
  logic           rdValid, rdReady = 0, rdStall = 0, rdTag, wbValid;
  logic [RAW-1:0] rdReg, wbReg;
  logic [63:0]    active;

  int  checks = 0, fails = 0;
  bit  finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  vls_seq #(.VBYTES(VB), .ADDR_W(32), .REG_AW(RAW)) i_vls_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdFunc(cmdFunc), .cmdSize(cmdSize), .cmdMulti(cmdMulti),
    .cmdReg(cmdReg), .cmdTag(cmdTag), .cmdAddr(cmdAddr), .cmdScalar(cmdScalar),
    .busValid(busValid), .busReady(busReady), .busAddr(busAddr), .busAltAddr(busAltAddr),
    .busBytes(busBytes), .busWrite(busWrite), .busLast(busLast),
    .rdValid(rdValid), .rdReady(rdReady), .rdStall(rdStall), .rdReg(rdReg), .rdTag(rdTag),
    .wbValid(wbValid), .wbReg(wbReg), .active(active)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic shuffle();
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    busReady = lfsr[0] | lfsr[3];
    rdReady  = lfsr[5] | lfsr[7];
    rdStall  = lfsr[9] & lfsr[2];
  endtask

  function automatic logic [63:0] expMask(bit store, int base, int g, int per, int n, int total);
    logic [63:0] m = '0;
    if (store && n < total)
      for (int j = 0; j < g; j++)
        if (n < (j + 1) * per) m[(base + j) & 63] = 1'b1;
    return m;
  endfunction

  task automatic runCmd(input int op, input int func, input int sz, input bit multi,
                        input int rg, input int tag, input logic [31:0] addr,
                        input logic [31:0] scalar, input bit junk);
    int g = multi ? 4 : 1;
    int per = (op == 2) ? 4 : 1;
    int total = g * per;
    bit store = (op != 0);
    int capEl = VB * g / sz;
    int budget = func[0] ? sz * ((scalar < 32'(capEl)) ? int'(scalar) : capEl) : VB * g;
    logic [31:0] step = func[1] ? 32'(scalar * 32'(sz)) : ((op == 2) ? 32'(VB / 4) : 32'(VB));
    int capB = (op == 2) ? VB / 4 : VB;
    int base = multi ? (rg & ~3) : rg;
    logic [31:0] eAddr = addr;
    int remain = budget;
    int k = 0, n = 0, cyc = 0, wbExp = 0;
    bit wbPend = 0;

    @(negedge clk);
    cmdValid = 1; cmdOp = 2'(op); cmdFunc = 2'(func); cmdSize = 3'(sz); cmdMulti = multi;
    cmdReg = RAW'(rg); cmdTag = 4'(tag); cmdAddr = addr; cmdScalar = scalar;
    #1 chk(cmdReady == 1'b1, "R1", "ready before accept", cmdReady, 1);
    @(negedge clk);
    while (k < total && cyc < 2000) begin
      // R1: a second command offered while busy must not disturb the sequence
      cmdValid = junk;
      if (junk) begin
        cmdOp = 2'd2 - cmdOp[1:0] / 2; cmdAddr = 32'hDEAD0000; cmdScalar = 32'd5;
        cmdMulti = ~multi; cmdReg = RAW'(rg + 17);
      end
      shuffle();
      #1;
      chk(cmdReady == 1'b0, "R1", "ready while busy", cmdReady, 0);
      chk(wbValid == wbPend, "R9", "wbValid", wbValid, wbPend);
      if (wbPend) chk(wbReg == RAW'(wbExp), "R9", "wbReg", wbReg, wbExp);
      chk(active == expMask(store, base, g, per, n, total), "R10", "active",
          active, expMask(store, base, g, per, n, total));
      chk(rdValid == (store && n < total), "R8", "rdValid", rdValid, store && n < total);
      chk(busValid == (!store || n > k), "R8", "busValid gating", busValid, !store || n > k);
      wbPend = 0;
      if (busValid) begin
        // R11: the offered beat is the current one whether or not it is accepted
        chk(busAddr == eAddr, busReady ? "R3" : "R11", "busAddr", busAddr, eAddr);
      end
      if (busValid && busReady) begin
        int bytes = (remain < capB) ? remain : capB;
        chk(busAltAddr == eAddr + 32'(VB), "R5", "busAltAddr", busAltAddr, eAddr + 32'(VB));
        chk(int'(busBytes) == bytes, "R4", "busBytes", busBytes, bytes);
        chk(busWrite == store, "R5", "busWrite", busWrite, store);
        chk(busLast == (k == total - 1), "R2", "busLast", busLast, k == total - 1);
        if (!store) begin wbPend = 1; wbExp = (base + k) & 63; end
        eAddr = eAddr + step;
        remain = remain - bytes;
        k++;
      end
      if (rdValid && rdReady && !rdStall) begin
        int er = (base + ((per == 4) ? n / 4 : n)) & 63;
        chk(int'(rdReg) == er, "R6", "rdReg", rdReg, er);
        chk(rdTag == 1'((tag >> (er & 3)) & 1), "R7", "rdTag", rdTag, (tag >> (er & 3)) & 1);
        n++;
      end
      @(negedge clk);
      cyc++;
    end
    cmdValid = 0;
    shuffle();
    #1;
    chk(k == total, "R2", "beat count", k, total);
    chk(cmdReady == 1'b1, "R1", "ready after last beat", cmdReady, 1);
    chk(busValid == 1'b0, "R2", "no beat after last", busValid, 0);
    chk(wbValid == wbPend, "R9", "final wbValid", wbValid, wbPend);
    if (wbPend) chk(wbReg == RAW'(wbExp), "R9", "final wbReg", wbReg, wbExp);
    chk(active == '0, "R10", "active idle", active, 0);
  endtask

  function automatic logic [31:0] pickScalar(int i);
    case (i % 8)
      0: return 32'd0;
      1: return 32'd3;
      2: return 32'd7;
      3: return 32'd16;
      4: return 32'd40;
      5: return 32'd100;
      6: return 32'd1;
      default: return 32'd64;
    endcase
  endfunction

  initial begin
    int idx = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(cmdReady == 1'b1, "R12", "reset ready", cmdReady, 1);
    chk(busValid == 1'b0, "R12", "reset busValid", busValid, 0);
    chk(rdValid == 1'b0, "R12", "reset rdValid", rdValid, 0);
    chk(wbValid == 1'b0, "R12", "reset wbValid", wbValid, 0);
    chk(active == '0, "R12", "reset active", active, 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int op = 0; op < 3; op++)
      for (int func = 0; func < 4; func++)
        for (int s = 0; s < 3; s++)
          for (int m = 0; m < 2; m++) begin
            runCmd(op, func, 1 << s, m[0], (idx * 11 + 5) % 64, idx % 16,
                   32'h1000 + 32'(idx * 64) + 32'(idx % 3), pickScalar(idx), idx[0]);
            idx++;
          end
    // address wrap near the top of the space, strided quarter-store in a group
    runCmd(2, 3, 4, 1'b1, 62, 4'hA, 32'hFFFF_FFF0, 32'd3, 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule